// File: doc/BRIEF.md
# Masked Priority Interrupt Controller with Daisy-Chain Arbitration

This block sits beside a processor's instruction sequencer and decides when an interrupt is taken. It keeps a global enable flag, a 16-level block mask and a latch for a power-fail event. It picks a winner among requesting devices that share a daisy chain. Each device presents a request line, a priority level and a device code. A device is eligible when the mask bit of its level is clear. Among eligible devices, the lowest level number wins. Within a level, the device at the lowest chain position, which is the one nearest the processor, wins.

Interrupts are only considered at instruction boundaries, which the sequencer marks with `instr_done_i`. When an interrupt is accepted, the block stalls the sequencer with `busy_o` and runs a fixed entry sequence. It writes the current PC to memory word 0, reads memory word 1, and loads the word it read into the PC. It also drops the global enable, so handlers do not nest until software turns interrupts back on.

Software reaches the block through a small operation port. Four operations are available: turn interrupts on, turn them off, load the mask, and acknowledge. Acknowledge returns the winning device code along with the accumulator index that the result is meant for.

Top module: `prio_intc`

## Requirements
- R1: Operation code 2 (mask load) copies `op_data_i` into the mask. A mask bit at 1 blocks every device whose level equals that bit's index, and a bit at 0 lets those devices through. The mask resets to all zeros.
- R2: Among eligible requesters at the same level, the one with the lowest chain index wins.
- R3: Among eligible requesters at different levels, the lowest level number wins, regardless of chain position.
- R4: Operation code 1 (interrupts off) clears the enable on the following cycle. Operation code 0 (interrupts on) does not set the enable directly. The enable becomes 1 at the first `instr_done_i` pulse seen after the operation, so no interrupt can be accepted at that boundary. The enable resets to 0.
- R5: While the enable is 0, device requests do not start an entry. An entry starts only on a cycle where `instr_done_i` is 1 and `busy_o` is 0.
- R6: Accepting an interrupt clears the enable in the same cycle that `busy_o` rises. A still-pending request is therefore not taken at later boundaries until interrupts are turned on again.
- R7: The entry sequence runs over three cycles. In the first, the block writes the PC captured at acceptance to address 0. In the next, it reads address 1. In the cycle after that, it asserts `pc_load_o`, with `pc_new_o` equal to the word read. `busy_o` is high for exactly those three cycles.
- R8: Operation code 3 (acknowledge) pulses `ack_valid_o` one cycle later. In that cycle, `ack_acc_o` equals `op_acc_i`, and `ack_code_o` equals the winner's code, or 0 when no device is eligible. The global enable does not affect this result.
- R9: A rising edge on `power_fail_i` latches a pending power-fail event. A pending event is accepted at the next boundary even when the enable is 0, the mask blocks every level, or no device requests. While the event is pending, acknowledge returns the code `PF_CODE` (all ones by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_done_i | input | 1 | Marks an instruction boundary |
| pc_i | input | AW | Current PC, saved on acceptance |
| op_valid_i | input | 1 | Operation strobe |
| op_kind_i | input | 2 | 0 on, 1 off, 2 mask load, 3 acknowledge |
| op_acc_i | input | 2 | Target accumulator for acknowledge |
| op_data_i | input | LVLS | Mask value for mask load |
| dev_req_i | input | NDEV | Request per chain position (index 0 nearest) |
| dev_level_i | input | NDEV*LVLW | Level per chain position |
| dev_code_i | input | NDEV*CODEW | Device code per chain position |
| power_fail_i | input | 1 | Power-fail warning |
| ien_o | output | 1 | Global interrupt enable |
| busy_o | output | 1 | Entry sequence in progress |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after read strobe |
| pc_load_o | output | 1 | Load PC with pc_new_o |
| pc_new_o | output | AW | Handler address |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_acc_o | output | 2 | Accumulator index for the result |
| ack_code_o | output | CODEW | Device code of the winner |

## Verification
The assertions assume the following about the environment:
- The memory returns read data on the cycle after the read strobe.
- `instr_done_i` is never raised while the block is busy, so no boundary arrives during an entry.
- Only one operation is presented per strobe.

The bench keeps within these assumptions in three ways:
- It drives a registered two-word memory model.
- It pulses `instr_done_i` only after the entry sequence has finished.
- It issues operations one at a time, away from clock edges.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic [1:0] {
      OP_ION  = 2'd0,
      OP_IOFF = 2'd1,
      OP_MASK = 2'd2,
      OP_ACK  = 2'd3
   } intc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SAVE  = 2'd1,
      ST_FETCH = 2'd2,
      ST_JUMP  = 2'd3
   } intc_state_e;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int NDEV      = 8,
   parameter int LVLS      = 16,
   parameter int CODEW     = 6,
   parameter bit LEVEL_ARB = 1'b1,
   localparam int LVLW     = $clog2(LVLS)
) (
   input  logic [NDEV-1:0]       req_i,
   input  logic [NDEV*LVLW-1:0]  level_i,
   input  logic [NDEV*CODEW-1:0] code_i,
   input  logic [LVLS-1:0]       mask_i,
   output logic                  any_o,
   output logic [CODEW-1:0]      code_o
);
   logic [NDEV-1:0] elig;
   logic [NDEV-1:0] at_lvl [LVLS];
   logic [LVLS-1:0] lvl_hit;

   for (genvar d = 0; d < NDEV; d++) begin : g_elig
      assign elig[d] = req_i[d] & ~mask_i[level_i[d*LVLW +: LVLW]];
   end

   for (genvar l = 0; l < LVLS; l++) begin : g_lvl
      for (genvar d = 0; d < NDEV; d++) begin : g_dev
         assign at_lvl[l][d] = elig[d] & (level_i[d*LVLW +: LVLW] == LVLW'(l));
      end
      assign lvl_hit[l] = |at_lvl[l];
   end

   logic [NDEV-1:0] cand;

   if (LEVEL_ARB) begin : g_level_first
      always_comb begin
         logic found;
         found = 1'b0;
         cand  = '0;
         for (int l = 0; l < LVLS; l++) begin
            if (!found && lvl_hit[l]) begin
               found = 1'b1;
               cand  = at_lvl[l];
            end
         end
      end
   end else begin : g_chain_only
      assign cand = elig;
   end

   always_comb begin
      logic found;
      found  = 1'b0;
      code_o = '0;
      for (int d = 0; d < NDEV; d++) begin
         if (!found && cand[d]) begin
            found  = 1'b1;
            code_o = code_i[d*CODEW +: CODEW];
         end
      end
      any_o = found;
   end
endmodule

// File: rtl/intc_enable_ctl.sv
module intc_enable_ctl
   import intc_pkg::*;
#(
   parameter int LVLS = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            op_valid_i,
   input  intc_op_e        op_kind_i,
   input  logic [LVLS-1:0] op_data_i,
   input  logic            boundary_i,
   input  logic            accept_i,
   input  logic            power_fail_i,
   output logic            ien_o,
   output logic [LVLS-1:0] mask_o,
   output logic            pf_pend_o
);
   logic ion_pend_q;
   logic pf_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ien_o      <= 1'b0;
         ion_pend_q <= 1'b0;
         mask_o     <= '0;
         pf_q       <= 1'b0;
         pf_pend_o  <= 1'b0;
      end else begin
         pf_q <= power_fail_i;
         if (accept_i) pf_pend_o <= 1'b0;
         if (power_fail_i && !pf_q) pf_pend_o <= 1'b1;

         if (accept_i) begin
            ien_o      <= 1'b0;
            ion_pend_q <= 1'b0;
         end else begin
            if (boundary_i && ion_pend_q) begin
               ien_o      <= 1'b1;
               ion_pend_q <= 1'b0;
            end
            if (op_valid_i && op_kind_i == OP_ION) ion_pend_q <= 1'b1;
            if (op_valid_i && op_kind_i == OP_IOFF) begin
               ien_o      <= 1'b0;
               ion_pend_q <= 1'b0;
            end
         end

         if (op_valid_i && op_kind_i == OP_MASK) mask_o <= op_data_i;
      end
   end
endmodule

// File: rtl/intc_entry_seq.sv
module intc_entry_seq
   import intc_pkg::*;
#(
   parameter int AW = 15,
   parameter int DW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [AW-1:0] pc_i,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          idle_o,
   output logic          mem_we_o,
   output logic          mem_re_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          pc_load_o,
   output logic [AW-1:0] pc_new_o
);
   localparam logic [AW-1:0] SAVE_ADDR = AW'(0);
   localparam logic [AW-1:0] VEC_ADDR  = AW'(1);

   intc_state_e   state_q;
   logic [AW-1:0] saved_pc_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         saved_pc_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q    <= ST_SAVE;
               saved_pc_q <= pc_i;
            end
            ST_SAVE:  state_q <= ST_FETCH;
            ST_FETCH: state_q <= ST_JUMP;
            ST_JUMP:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign idle_o      = (state_q == ST_IDLE);
   assign mem_we_o    = (state_q == ST_SAVE);
   assign mem_re_o    = (state_q == ST_FETCH);
   assign mem_addr_o  = (state_q == ST_FETCH) ? VEC_ADDR : SAVE_ADDR;
   assign mem_wdata_o = DW'(saved_pc_q);
   assign pc_load_o   = (state_q == ST_JUMP);
   assign pc_new_o    = mem_rdata_i[AW-1:0];
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import intc_pkg::*;
#(
   parameter int            NDEV      = 8,
   parameter int            LVLS      = 16,
   parameter int            CODEW     = 6,
   parameter int            AW        = 15,
   parameter int            DW        = 16,
   parameter bit            LEVEL_ARB = 1'b1,
   parameter logic [CODEW-1:0] PF_CODE = '1,
   localparam int           LVLW      = $clog2(LVLS)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  instr_done_i,
   input  logic [AW-1:0]         pc_i,
   input  logic                  op_valid_i,
   input  logic [1:0]            op_kind_i,
   input  logic [1:0]            op_acc_i,
   input  logic [LVLS-1:0]       op_data_i,
   input  logic [NDEV-1:0]       dev_req_i,
   input  logic [NDEV*LVLW-1:0]  dev_level_i,
   input  logic [NDEV*CODEW-1:0] dev_code_i,
   input  logic                  power_fail_i,
   output logic                  ien_o,
   output logic                  busy_o,
   output logic                  mem_we_o,
   output logic                  mem_re_o,
   output logic [AW-1:0]         mem_addr_o,
   output logic [DW-1:0]         mem_wdata_o,
   input  logic [DW-1:0]         mem_rdata_i,
   output logic                  pc_load_o,
   output logic [AW-1:0]         pc_new_o,
   output logic                  ack_valid_o,
   output logic [1:0]            ack_acc_o,
   output logic [CODEW-1:0]      ack_code_o
);
   if (NDEV < 1) begin : g_chk_ndev
      $error("NDEV must be at least 1");
   end
   if (LVLS < 2 || LVLS != (1 << LVLW)) begin : g_chk_lvls
      $error("LVLS must be a power of two, at least 2");
   end
   if (DW < AW) begin : g_chk_dw
      $error("DW must hold a full PC");
   end
   if (AW < 2) begin : g_chk_aw
      $error("AW must address words 0 and 1");
   end

   intc_op_e        op_kind;
   logic [LVLS-1:0] mask;
   logic            pf_pend;
   logic            any_req;
   logic [CODEW-1:0] win_code;
   logic            idle;
   logic            boundary;
   logic            accept;

   assign op_kind  = intc_op_e'(op_kind_i);
   assign boundary = instr_done_i & idle;
   assign accept   = boundary & (pf_pend | (ien_o & any_req));
   assign busy_o   = ~idle;

   intc_arbiter #(
      .NDEV(NDEV), .LVLS(LVLS), .CODEW(CODEW), .LEVEL_ARB(LEVEL_ARB)
   ) u_arb (
      .req_i  (dev_req_i),
      .level_i(dev_level_i),
      .code_i (dev_code_i),
      .mask_i (mask),
      .any_o  (any_req),
      .code_o (win_code)
   );

   intc_enable_ctl #(.LVLS(LVLS)) u_en (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .op_valid_i  (op_valid_i),
      .op_kind_i   (op_kind),
      .op_data_i   (op_data_i),
      .boundary_i  (boundary),
      .accept_i    (accept),
      .power_fail_i(power_fail_i),
      .ien_o       (ien_o),
      .mask_o      (mask),
      .pf_pend_o   (pf_pend)
   );

   intc_entry_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (accept),
      .pc_i       (pc_i),
      .mem_rdata_i(mem_rdata_i),
      .idle_o     (idle),
      .mem_we_o   (mem_we_o),
      .mem_re_o   (mem_re_o),
      .mem_addr_o (mem_addr_o),
      .mem_wdata_o(mem_wdata_o),
      .pc_load_o  (pc_load_o),
      .pc_new_o   (pc_new_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ack_valid_o <= 1'b0;
         ack_acc_o   <= '0;
         ack_code_o  <= '0;
      end else begin
         ack_valid_o <= op_valid_i && op_kind == OP_ACK;
         if (op_valid_i && op_kind == OP_ACK) begin
            ack_acc_o  <= op_acc_i;
            ack_code_o <= pf_pend ? PF_CODE : win_code;
         end
      end
   end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
   parameter int AW = 15
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          instr_done_i,
   input logic          op_valid_i,
   input logic [1:0]    op_kind_i,
   input logic          ien_o,
   input logic          busy_o,
   input logic          mem_we_o,
   input logic          mem_re_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          pc_load_o,
   input logic          ack_valid_o
);
   p_entry_clears_ien_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> !ien_o);

   p_save_at_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |-> (mem_addr_o == AW'(0) && busy_o));

   p_fetch_at_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_re_o |-> (mem_addr_o == AW'(1) && busy_o));

   p_write_then_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |=> mem_re_o);

   p_read_then_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_re_o |=> pc_load_o);

   p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({mem_we_o, mem_re_o, pc_load_o}));

   p_ion_delayed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_kind_i == 2'd0 && !ien_o && !instr_done_i) |=> !ien_o);

   p_ioff_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_kind_i == 2'd1) |=> !ien_o);

   p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_kind_i == 2'd3) |=> ack_valid_o);
endmodule

bind prio_intc intc_checker #(.AW(AW)) u_intc_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .instr_done_i(instr_done_i),
   .op_valid_i  (op_valid_i),
   .op_kind_i   (op_kind_i),
   .ien_o       (ien_o),
   .busy_o      (busy_o),
   .mem_we_o    (mem_we_o),
   .mem_re_o    (mem_re_o),
   .mem_addr_o  (mem_addr_o),
   .pc_load_o   (pc_load_o),
   .ack_valid_o (ack_valid_o)
);

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
   localparam int NDEV = 8, LVLS = 16, LVLW = 4, CODEW = 6, AW = 15, DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic instr_done = 1'b0;
   logic [AW-1:0] pc = '0;
   logic op_valid = 1'b0;
   logic [1:0] op_kind = '0, op_acc = '0;
   logic [LVLS-1:0] op_data = '0;
   logic [NDEV-1:0] req = '0;
   logic [NDEV*LVLW-1:0] lvl = '0;
   logic [NDEV*CODEW-1:0] code;
   logic pf = 1'b0;
   logic ien, busy, we, re, pcl, ackv;
   logic [AW-1:0] addr, pcn;
   logic [DW-1:0] wdata, rdata;
   logic [1:0] acka;
   logic [CODEW-1:0] ackc;
   logic [DW-1:0] mem0, mem1;

   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   prio_intc dut_i (
      .clk_i(clk), .rst_ni(rst_n), .instr_done_i(instr_done), .pc_i(pc),
      .op_valid_i(op_valid), .op_kind_i(op_kind), .op_acc_i(op_acc),
      .op_data_i(op_data), .dev_req_i(req), .dev_level_i(lvl),
      .dev_code_i(code), .power_fail_i(pf), .ien_o(ien), .busy_o(busy),
      .mem_we_o(we), .mem_re_o(re), .mem_addr_o(addr), .mem_wdata_o(wdata),
      .mem_rdata_i(rdata), .pc_load_o(pcl), .pc_new_o(pcn),
      .ack_valid_o(ackv), .ack_acc_o(acka), .ack_code_o(ackc)
   );

   always_ff @(posedge clk) begin
      if (we && addr == '0) mem0 <= wdata;
      if (re) rdata <= (addr == AW'(1)) ? mem1 : 16'hDEAD;
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req_tag, int actual, int expected);
      n_chk++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req_tag, actual, expected);
      end
   endtask

   task automatic do_op(int kind, int acc, int data);
      op_valid = 1'b1;
      op_kind  = 2'(kind);
      op_acc   = 2'(acc);
      op_data  = LVLS'(data);
      tick();
      op_valid = 1'b0;
   endtask

   task automatic boundary();
      instr_done = 1'b1;
      tick();
      instr_done = 1'b0;
   endtask

   function automatic int dcode(int d);
      return d + 5;
   endfunction

   // reference winner: lowest level first, then lowest chain index
   function automatic int ref_win(logic [NDEV-1:0] r, logic [LVLS-1:0] m);
      int best_l = LVLS, best_d = -1;
      for (int d = 0; d < NDEV; d++) begin
         int l = int'(lvl[d*LVLW +: LVLW]);
         if (r[d] && !m[l] && l < best_l) begin
            best_l = l;
            best_d = d;
         end
      end
      return (best_d < 0) ? 0 : dcode(best_d);
   endfunction

   initial begin
      #(4 * 200000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int d = 0; d < NDEV; d++) code[d*CODEW +: CODEW] = CODEW'(dcode(d));
      mem1 = 16'h0456;
      mem0 = '0;
      rdata = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // reset state
      check("R4 reset ien", int'(ien), 0);
      check("R7 reset busy", int'(busy), 0);
      do_op(3, 0, 0);
      check("R8 ack with no request", int'(ackc), 0);
      req = 8'h01; lvl = '0;
      do_op(3, 0, 0);
      check("R1 reset mask open", int'(ackc), dcode(0));

      // R1 mask sweep over every level and chain position
      for (int l = 0; l < LVLS; l++) begin
         for (int d = 0; d < NDEV; d++) begin
            lvl = '0;
            lvl[d*LVLW +: LVLW] = LVLW'(l);
            req = NDEV'(1) << d;
            do_op(2, 0, 1 << l);
            do_op(3, d % 4, 0);
            check("R1 blocked level", int'(ackc), 0);
            do_op(2, 0, ~(1 << l));
            do_op(3, d % 4, 0);
            check("R1 open level", int'(ackc), dcode(d));
            check("R8 acc index", int'(acka), d % 4);
         end
      end

      // R2 chain order, all devices on one level
      lvl = '0;
      for (int d = 0; d < NDEV; d++) lvl[d*LVLW +: LVLW] = 4'd7;
      do_op(2, 0, 0);
      for (int p = 0; p < 256; p++) begin
         req = NDEV'(p);
         do_op(3, 1, 0);
         check("R2 chain position", int'(ackc), ref_win(req, '0));
      end

      // R3 level priority over chain position
      for (int d = 0; d < NDEV; d++) lvl[d*LVLW +: LVLW] = LVLW'((15 - 2 * d) ^ (d & 1));
      lvl[5*LVLW +: LVLW] = lvl[6*LVLW +: LVLW];
      for (int k = 0; k < 2; k++) begin
         logic [LVLS-1:0] m = (k == 0) ? 16'h0000 : 16'h0A02;
         do_op(2, 0, int'(m));
         for (int p = 0; p < 256; p++) begin
            req = NDEV'(p);
            do_op(3, 2, 0);
            check("R3 level priority", int'(ackc), ref_win(req, m));
         end
      end

      // R5 requests ignored while enable is clear
      do_op(2, 0, 0);
      req = 8'h04;
      pc = 15'h1234;
      boundary();
      check("R5 no entry with enable clear", int'(busy), 0);

      // R4 delayed enable
      do_op(0, 0, 0);
      check("R4 on not immediate", int'(ien), 0);
      boundary();
      check("R4 no entry at first boundary", int'(busy), 0);
      check("R4 enable after boundary", int'(ien), 1);

      // R7 entry sequence, R6 enable cleared
      boundary();
      check("R7 busy on entry", int'(busy), 1);
      check("R7 write strobe", int'(we), 1);
      check("R7 save address", int'(addr), 0);
      check("R7 save data", int'(wdata), 16'h1234);
      check("R6 enable cleared on entry", int'(ien), 0);
      tick();
      check("R7 read strobe", int'(re), 1);
      check("R7 vector address", int'(addr), 1);
      check("R7 saved word", int'(mem0), 16'h1234);
      tick();
      check("R7 pc load", int'(pcl), 1);
      check("R7 handler address", int'(pcn), 16'h0456);
      tick();
      check("R7 busy ends", int'(busy), 0);
      boundary();
      check("R6 no nesting", int'(busy), 0);

      // R4 interrupt off
      do_op(0, 0, 0);
      boundary();
      check("R4 enable set", int'(ien), 1);
      do_op(1, 0, 0);
      check("R4 off clears", int'(ien), 0);
      boundary();
      check("R4 off blocks entry", int'(busy), 0);

      // R1 mask blocks entry with enable set (device 2 level read from lvl)
      do_op(2, 0, 1 << int'(lvl[2*LVLW +: LVLW]));
      do_op(0, 0, 0);
      boundary();
      boundary();
      check("R1 masked request not taken", int'(busy), 0);

      // R9 power fail overrides enable, mask and chain
      do_op(1, 0, 0);
      do_op(2, 0, 16'hFFFF);
      req = '0;
      pf = 1'b1;
      tick();
      do_op(3, 3, 0);
      check("R9 ack power fail code", int'(ackc), 6'h3F);
      pc = 15'h0077;
      boundary();
      check("R9 forced entry", int'(busy), 1);
      check("R9 saved pc", int'(wdata), 16'h0077);
      repeat (3) tick();
      boundary();
      check("R9 level held pf taken once", int'(busy), 0);
      pf = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule